// File: doc/BRIEF.md
# Checksummed I2C Register Access Sequencer

This block runs complete register transactions on a device whose 15-bit register space is reached over I2C through combined accesses protected by an 8-bit checksum. A command names the 7-bit bus address of the device, the 15-bit register, a 16-bit value for writes and the direction. The engine builds a two-byte register header whose low bit marks the direction. It computes the checksum and walks the fixed byte sequence through a byte-level I2C master below it. That lower layer accepts one operation at a time (start, repeated start, stop, send a byte and report the ACK, receive a byte and answer ACK or NACK, bus clear) and owns all bit timing.

When any byte is not acknowledged, or the lower layer reports a bus fault, the attempt is abandoned. The engine clears the bus and starts over from the first START. Reads get up to ten attempts and writes get one. Each transaction ends with a one-cycle done pulse that carries an error flag, the 16-bit read value and the number of attempts used.

Top module: `i2c_csum_regx`

## Requirements
- R1: The first register-header byte sent is register bits 14:8 placed in bits 7:1, with bit 0 set to 1 for a read and 0 for a write. The second header byte is register bits 7:0. The device-address byte is the address in bits 7:1 with bit 0 = 0 for the write phase and 1 for the read phase.
- R2: For a read, the checksum byte sent is the bitwise inverse of the end-around-carry 8-bit sum of the two header bytes.
- R3: For a write, the checksum byte sent is the bitwise inverse of the end-around-carry 8-bit sum of the two header bytes, the data high byte and the data low byte.
- R4: Lower-layer operation codes on bm_op are 0 start, 1 repeated start, 2 stop, 3 send byte, 4 receive byte, 5 bus clear. A successful read issues: start, send address(write), send header high, send header low, send checksum, repeated start, send address(read), receive, receive, receive, stop.
- R5: A successful write issues: start, send address(write), send header high, send header low, send data high, send data low, send checksum, stop.
- R6: The first two received bytes of a read are answered with ACK (bm_rx_nack = 0). The third (checksum) byte is answered with NACK (bm_rx_nack = 1), and stop follows.
- R7: A send that completes without ACK, or any operation that completes with bm_fault, ends the attempt at once. The next operation is a bus clear, and a retry starts again with start.
- R8: A read is attempted at most 10 times. If all attempts fail, the done pulse carries rsp_err = 1 and rsp_tries = 10. Otherwise rsp_tries is the number of attempts used.
- R9: A write is attempted exactly once. A failure gives rsp_err = 1 with rsp_tries = 1.
- R10: A successful read returns rsp_rdata = {first received byte, second received byte}.
- R11: With checksum checking enabled, a received checksum byte that differs from the inverse of the end-around-carry sum of the two data bytes makes the read finish with rsp_err = 1 and no retry.
- R12: cmd_ready is high only while idle. A command presented while busy is ignored and does not change the running transaction.
- R13: rsp_done is high for exactly one cycle per transaction. It also marks the cycle in which cmd_ready returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command taken on this edge |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_dev | input | 7 | Device bus address |
| cmd_reg | input | 15 | Register address |
| cmd_wdata | input | 16 | Write value |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Transaction failed |
| rsp_rdata | output | 16 | Read value |
| rsp_tries | output | TRY_W | Attempts used |
| bm_req | output | 1 | Operation request to byte master, held until bm_done |
| bm_op | output | 3 | Operation code |
| bm_txd | output | 8 | Byte to send |
| bm_rx_nack | output | 1 | Answer to a received byte: 1 = NACK |
| bm_done | input | 1 | Operation complete |
| bm_ack_ok | input | 1 | Slave acknowledged the sent byte |
| bm_fault | input | 1 | Bus error during the operation |
| bm_rxd | input | 8 | Received byte |

## Verification
The completion pulse and the acceptance of the next command share a cycle. In that cycle the engine is idle again, so a command already waiting on the port is taken at the next edge. The bench holds a second command valid across the whole of a first read. It then checks that the second command had no effect during the read and that the read finished with its own data and count. It also checks that the write starts immediately after the read, with both complete operation streams in order.

// File: rtl/i2c_csum_regx.sv
module i2c_csum_regx #(
  parameter int READ_TRIES    = 10,
  parameter int WRITE_TRIES   = 1,
  parameter bit CHECK_RX_CSUM = 1'b1,
  localparam int MAX_TRIES    = (READ_TRIES > WRITE_TRIES) ? READ_TRIES : WRITE_TRIES,
  localparam int TRY_W        = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [6:0]       cmd_dev,
  input  logic [14:0]      cmd_reg,
  input  logic [15:0]      cmd_wdata,
  output logic             rsp_done,
  output logic             rsp_err,
  output logic [15:0]      rsp_rdata,
  output logic [TRY_W-1:0] rsp_tries,
  output logic             bm_req,
  output logic [2:0]       bm_op,
  output logic [7:0]       bm_txd,
  output logic             bm_rx_nack,
  input  logic             bm_done,
  input  logic             bm_ack_ok,
  input  logic             bm_fault,
  input  logic [7:0]       bm_rxd
);

  localparam logic [2:0] OP_START   = 3'd0;
  localparam logic [2:0] OP_RESTART = 3'd1;
  localparam logic [2:0] OP_STOP    = 3'd2;
  localparam logic [2:0] OP_SEND    = 3'd3;
  localparam logic [2:0] OP_RECV    = 3'd4;
  localparam logic [2:0] OP_CLEAR   = 3'd5;

  localparam logic [3:0] LAST_RD = 4'd10;
  localparam logic [3:0] LAST_WR = 4'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_CLEAR} state_t;

  state_t            state;
  logic [3:0]        step;
  logic              wr_q;
  logic [6:0]        dev_q;
  logic [14:0]       reg_q;
  logic [15:0]       wd_q;
  logic [TRY_W-1:0]  tries_q;
  logic [7:0]        rx_hi, rx_lo, rx_ck;
  logic              done_q, err_q;

  function automatic logic [7:0] oc_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  logic [7:0] hdr_hi, hdr_lo, ck_tx, ck_rx_exp;
  assign hdr_hi    = {reg_q[14:8], ~wr_q};
  assign hdr_lo    = reg_q[7:0];
  assign ck_tx     = wr_q ? ~oc_add(oc_add(oc_add(hdr_hi, hdr_lo), wd_q[15:8]), wd_q[7:0])
                          : ~oc_add(hdr_hi, hdr_lo);
  assign ck_rx_exp = ~oc_add(rx_hi, rx_lo);

  logic [3:0]       last_step;
  logic [TRY_W-1:0] limit;
  assign last_step = wr_q ? LAST_WR : LAST_RD;
  assign limit     = wr_q ? TRY_W'(WRITE_TRIES) : TRY_W'(READ_TRIES);

  always_comb begin
    bm_op      = OP_CLEAR;
    bm_txd     = 8'h00;
    bm_rx_nack = 1'b0;
    if (state == ST_RUN) begin
      if (wr_q) begin
        case (step)
          4'd0:    bm_op = OP_START;
          4'd1:    begin bm_op = OP_SEND; bm_txd = {dev_q, 1'b0}; end
          4'd2:    begin bm_op = OP_SEND; bm_txd = hdr_hi; end
          4'd3:    begin bm_op = OP_SEND; bm_txd = hdr_lo; end
          4'd4:    begin bm_op = OP_SEND; bm_txd = wd_q[15:8]; end
          4'd5:    begin bm_op = OP_SEND; bm_txd = wd_q[7:0]; end
          4'd6:    begin bm_op = OP_SEND; bm_txd = ck_tx; end
          default: bm_op = OP_STOP;
        endcase
      end else begin
        case (step)
          4'd0:    bm_op = OP_START;
          4'd1:    begin bm_op = OP_SEND; bm_txd = {dev_q, 1'b0}; end
          4'd2:    begin bm_op = OP_SEND; bm_txd = hdr_hi; end
          4'd3:    begin bm_op = OP_SEND; bm_txd = hdr_lo; end
          4'd4:    begin bm_op = OP_SEND; bm_txd = ck_tx; end
          4'd5:    bm_op = OP_RESTART;
          4'd6:    begin bm_op = OP_SEND; bm_txd = {dev_q, 1'b1}; end
          4'd7:    bm_op = OP_RECV;
          4'd8:    bm_op = OP_RECV;
          4'd9:    begin bm_op = OP_RECV; bm_rx_nack = 1'b1; end
          default: bm_op = OP_STOP;
        endcase
      end
    end
  end

  logic attempt_fail;
  assign attempt_fail = bm_fault || (bm_op == OP_SEND && !bm_ack_ok);

  assign bm_req    = (state != ST_IDLE);
  assign cmd_ready = (state == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = {rx_hi, rx_lo};
  assign rsp_tries = tries_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      step    <= 4'd0;
      wr_q    <= 1'b0;
      dev_q   <= 7'd0;
      reg_q   <= 15'd0;
      wd_q    <= 16'd0;
      tries_q <= '0;
      rx_hi   <= 8'd0;
      rx_lo   <= 8'd0;
      rx_ck   <= 8'd0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          wr_q    <= cmd_write;
          dev_q   <= cmd_dev;
          reg_q   <= cmd_reg;
          wd_q    <= cmd_wdata;
          tries_q <= TRY_W'(1);
          step    <= 4'd0;
          err_q   <= 1'b0;
          state   <= ST_RUN;
        end
        ST_RUN: if (bm_done) begin
          if (attempt_fail) begin
            state <= ST_CLEAR;
          end else begin
            if (!wr_q && step == 4'd7) rx_hi <= bm_rxd;
            if (!wr_q && step == 4'd8) rx_lo <= bm_rxd;
            if (!wr_q && step == 4'd9) rx_ck <= bm_rxd;
            if (step == last_step) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
              err_q  <= CHECK_RX_CSUM && !wr_q && (rx_ck != ck_rx_exp);
            end else begin
              step <= step + 4'd1;
            end
          end
        end
        ST_CLEAR: if (bm_done) begin
          if (tries_q >= limit) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            tries_q <= tries_q + TRY_W'(1);
            step    <= 4'd0;
            state   <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R12
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bm_req);

  // R8
  tries_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_tries >= TRY_W'(1) && rsp_tries <= TRY_W'(READ_TRIES)));

  // R9
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && wr_q) |-> rsp_tries <= TRY_W'(WRITE_TRIES));

  // R4
  op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> bm_op <= OP_CLEAR);

  // R7
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_done && bm_fault && bm_op != OP_CLEAR) |=> (bm_req && bm_op == OP_CLEAR));

endmodule

// File: tb/i2c_csum_regx_bench.sv
module i2c_csum_regx_bench;
  localparam int TRY_W = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0;
  logic [6:0] cmd_dev = 0;
  logic [14:0] cmd_reg = 0;
  logic [15:0] cmd_wdata = 0;
  logic cmd_ready, rsp_done, rsp_err, bm_req, bm_rx_nack;
  logic [15:0] rsp_rdata;
  logic [TRY_W-1:0] rsp_tries;
  logic [2:0] bm_op;
  logic [7:0] bm_txd;
  logic bm_done = 0, bm_ack_ok = 0, bm_fault = 0;
  logic [7:0] bm_rxd = 0;

  always #5 clk = ~clk;

  i2c_csum_regx u_i2c_csum_regx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .rsp_tries(rsp_tries),
    .bm_req(bm_req), .bm_op(bm_op), .bm_txd(bm_txd), .bm_rx_nack(bm_rx_nack),
    .bm_done(bm_done), .bm_ack_ok(bm_ack_ok), .bm_fault(bm_fault), .bm_rxd(bm_rxd));

  typedef struct packed {
    logic        wr;
    logic [6:0]  dev;
    logic [14:0] rg;
    logic [15:0] wd;
    logic [7:0]  rxh;
    logic [7:0]  rxl;
    logic        ckbad;
    logic [3:0]  nfail;
    logic [3:0]  fstep;
    logic        fkind;
    logic        xerr;
    logic [3:0]  xtries;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'h50, 15'h1234, 16'h0000, 8'hAB, 8'hCD, 1'b0, 4'd0,  4'd0, 1'b0, 1'b0, 4'd1},
    '{1'b1, 7'h3C, 15'h7FFF, 16'hFFFF, 8'h00, 8'h00, 1'b0, 4'd0,  4'd0, 1'b0, 1'b0, 4'd1},
    '{1'b0, 7'h11, 15'h0000, 16'h0000, 8'h00, 8'h00, 1'b0, 4'd2,  4'd2, 1'b0, 1'b0, 4'd3},
    '{1'b0, 7'h7F, 15'h5A5A, 16'h0000, 8'hFF, 8'h01, 1'b0, 4'd1,  4'd8, 1'b1, 1'b0, 4'd2},
    '{1'b0, 7'h22, 15'h0100, 16'h0000, 8'h12, 8'h34, 1'b0, 4'd10, 4'd1, 1'b0, 1'b1, 4'd10},
    '{1'b1, 7'h45, 15'h0F0F, 16'h8001, 8'h00, 8'h00, 1'b0, 4'd1,  4'd6, 1'b0, 1'b1, 4'd1},
    '{1'b0, 7'h09, 15'h3333, 16'h0000, 8'h80, 8'h80, 1'b1, 4'd0,  4'd0, 1'b0, 1'b1, 4'd1},
    '{1'b1, 7'h01, 15'h4080, 16'h8001, 8'h00, 8'h00, 1'b0, 4'd1,  4'd0, 1'b1, 1'b1, 4'd1},
    '{1'b0, 7'h66, 15'h2AFE, 16'h0000, 8'hFE, 8'hFF, 1'b0, 4'd9,  4'd4, 1'b0, 1'b0, 4'd10}
  };

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0;

  logic [11:0] got_log [256];
  int got_n = 0;
  logic [11:0] exp_log [256];
  int exp_n = 0;

  logic [7:0] m_rxh = 0, m_rxl = 0, m_rxc = 0;
  int m_fails_left = 0, m_fstep = 0, m_fkind = 0, m_idx = 0;

  function automatic logic [7:0] ocs(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s > 255) s = s - 255;
    return s[7:0];
  endfunction

  function automatic logic [11:0] ent(input logic [2:0] op, input logic nk, input logic [7:0] d);
    return {op, nk, d};
  endfunction

  function automatic logic [11:0] step_ent(input vec_t v, input int s);
    logic [7:0] hh, hl, ck;
    hh = {v.rg[14:8], ~v.wr};
    hl = v.rg[7:0];
    if (v.wr) begin
      ck = ~ocs(ocs(ocs(hh, hl), v.wd[15:8]), v.wd[7:0]);
      case (s)
        0: return ent(3'd0, 0, 8'h00);
        1: return ent(3'd3, 0, {v.dev, 1'b0});
        2: return ent(3'd3, 0, hh);
        3: return ent(3'd3, 0, hl);
        4: return ent(3'd3, 0, v.wd[15:8]);
        5: return ent(3'd3, 0, v.wd[7:0]);
        6: return ent(3'd3, 0, ck);
        default: return ent(3'd2, 0, 8'h00);
      endcase
    end else begin
      ck = ~ocs(hh, hl);
      case (s)
        0: return ent(3'd0, 0, 8'h00);
        1: return ent(3'd3, 0, {v.dev, 1'b0});
        2: return ent(3'd3, 0, hh);
        3: return ent(3'd3, 0, hl);
        4: return ent(3'd3, 0, ck);
        5: return ent(3'd1, 0, 8'h00);
        6: return ent(3'd3, 0, {v.dev, 1'b1});
        7: return ent(3'd4, 0, 8'h00);
        8: return ent(3'd4, 0, 8'h00);
        9: return ent(3'd4, 1, 8'h00);
        default: return ent(3'd2, 0, 8'h00);
      endcase
    end
  endfunction

  task automatic build_exp(input vec_t v);
    int nat, full;
    full = v.wr ? 8 : 11;
    nat = v.wr ? 1 : ((int'(v.nfail) + 1 > 10) ? 10 : int'(v.nfail) + 1);
    for (int a = 0; a < nat; a++) begin
      if (a < int'(v.nfail)) begin
        for (int s = 0; s <= int'(v.fstep); s++) begin exp_log[exp_n] = step_ent(v, s); exp_n++; end
        exp_log[exp_n] = ent(3'd5, 0, 8'h00); exp_n++;
      end else begin
        for (int s = 0; s < full; s++) begin exp_log[exp_n] = step_ent(v, s); exp_n++; end
      end
    end
  endtask

  task automatic setup_model(input vec_t v);
    m_rxh = v.rxh;
    m_rxl = v.rxl;
    m_rxc = ~ocs(v.rxh, v.rxl) ^ (v.ckbad ? 8'h5A : 8'h00);
    m_fails_left = int'(v.nfail);
    m_fstep = int'(v.fstep);
    m_fkind = int'(v.fkind);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_log(input string req);
    int bad_at;
    bad_at = -1;
    if (got_n == exp_n)
      for (int i = 0; i < exp_n; i++) if (bad_at < 0 && got_log[i] !== exp_log[i]) bad_at = i;
    n_chk++;
    if (got_n != exp_n) begin
      n_bad++;
      $display("FAIL %s op count actual=%0d expected=%0d", req, got_n, exp_n);
    end else if (bad_at >= 0) begin
      n_bad++;
      $display("FAIL %s op %0d actual=%0h expected=%0h", req, bad_at, got_log[bad_at], exp_log[bad_at]);
    end
  endtask

  // byte-level master model
  initial begin
    forever begin
      @(negedge clk);
      if (bm_req) begin
        logic [2:0] op;
        logic [7:0] txd;
        logic nk;
        op = bm_op; txd = bm_txd; nk = bm_rx_nack;
        if (op == 3'd0) m_idx = 0;
        got_log[got_n] = {op, (op == 3'd4) ? nk : 1'b0, (op == 3'd3) ? txd : 8'h00};
        got_n++;
        @(negedge clk);
        bm_ack_ok = (op == 3'd3);
        bm_fault = 0;
        bm_rxd = 8'h00;
        if (op == 3'd4) bm_rxd = (m_idx == 7) ? m_rxh : (m_idx == 8) ? m_rxl : m_rxc;
        if (op == 3'd5) m_fails_left = m_fails_left - 1;
        else if (m_fails_left > 0 && m_idx == m_fstep) begin
          if (m_fkind == 0 && op == 3'd3) bm_ack_ok = 0;
          else bm_fault = 1;
        end
        m_idx++;
        bm_done = 1;
        @(negedge clk);
        bm_done = 0; bm_ack_ok = 0; bm_fault = 0;
      end
    end
  end

  always @(posedge clk) if (rsp_done) done_cnt++;

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic run_vec(input vec_t v, output logic e, output logic [15:0] rd, output logic [3:0] t);
    setup_model(v);
    got_n = 0; exp_n = 0;
    build_exp(v);
    @(negedge clk);
    cmd_valid = 1; cmd_write = v.wr; cmd_dev = v.dev; cmd_reg = v.rg; cmd_wdata = v.wd;
    @(negedge clk);
    cmd_valid = 0;
    while (!rsp_done) @(negedge clk);
    e = rsp_err; rd = rsp_rdata; t = rsp_tries;
    @(negedge clk);
    check("R13 done pulse width", rsp_done, 0);
  endtask

  initial begin
    logic e;
    logic [15:0] rd;
    logic [3:0] t;
    int dc0;
    vec_t va, vb;

    repeat (3) @(negedge clk);
    check("R12 reset ready", cmd_ready, 1);
    check("R13 reset done", rsp_done, 0);
    check("R4 reset no request", bm_req, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 via the table
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], e, rd, t);
      check_log(VECS[i].wr ? "R1 R3 R5 R7 R9 op stream" : "R1 R2 R4 R6 R7 R8 op stream");
      check(VECS[i].ckbad ? "R11 error flag" : "R8 R9 error flag", e, VECS[i].xerr);
      check("R8 R9 attempt count", t, VECS[i].xtries);
      if (!VECS[i].wr && !VECS[i].xerr) check("R10 read value", rd, {VECS[i].rxh, VECS[i].rxl});
      check("R12 ready after done", cmd_ready, 1);
    end

    // R12 R13: second command held valid during a read, accepted in the done cycle
    va = VECS[0];
    vb = VECS[1];
    setup_model(va);
    got_n = 0; exp_n = 0;
    build_exp(va);
    build_exp(vb);
    dc0 = done_cnt;
    @(negedge clk);
    cmd_valid = 1; cmd_write = va.wr; cmd_dev = va.dev; cmd_reg = va.rg; cmd_wdata = va.wd;
    @(negedge clk);
    cmd_write = vb.wr; cmd_dev = vb.dev; cmd_reg = vb.rg; cmd_wdata = vb.wd;
    check("R12 busy not ready", cmd_ready, 0);
    while (!rsp_done) @(negedge clk);
    check("R13 ready with done", cmd_ready, 1);
    check("R10 first result data", rsp_rdata, {va.rxh, va.rxl});
    check("R12 first result error", rsp_err, 0);
    @(negedge clk);
    check("R12 second command taken", cmd_ready, 0);
    cmd_valid = 0;
    while (!rsp_done) @(negedge clk);
    check("R9 second result error", rsp_err, 0);
    @(negedge clk);
    check("R13 two done pulses", done_cnt - dc0, 2);
    check_log("R12 R13 back-to-back op stream");

    finish_run();
  end
endmodule